// File: doc/BRIEF.md
# Banked Load/Store Port Arbiter

This block sits in front of a data cache array that is split into single-ported banks. It makes the array look as if it has one load port and one store port. Each cycle it takes at most one load and one store. Each request carries an address. A few address bits pick a bank.

When the load and the store go to different banks, both reach the array in the same cycle. When they go to the same bank, the load always wins. The store then waits in a small in-order buffer and is retried on later cycles. Because a load is never held back, load latency stays fixed. Operations scheduled behind a load never have to be replayed.

The upstream store source sees a ready signal. It must hold its request until the store is accepted. The block drives one-hot bank enables for the load side and the store side. It also presents the address and data of the store being written. Tags, misses, forwarding and the array contents are outside this block.

Top module: `ldst_bank_arb`

## Requirements
- R1: The bank of an access is address bits [5:3] (8 banks of 8 bytes). `ld_bank_en` is one-hot with bit `addr[5:3]` set while `ld_valid` is high, and all zero otherwise.
- R2: A presented load is granted in the same cycle, with no exception: `ld_grant` equals `ld_valid` in every cycle.
- R3: In no cycle do `ld_bank_en` and `st_bank_en` have a common bit set.
- R4: With the store buffer empty, an accepted store whose bank differs from the load's bank (or with no load) is written in the same cycle. `wr_valid` is 1, `wr_addr`/`wr_data` carry the request, and `st_bank_en` is one-hot on its bank. `st_bank_en` is all zero whenever `wr_valid` is 0.
- R5: When the store candidate and the load target the same bank, the load is granted and no store is written that cycle.
- R6: Stores are written in the order they were accepted. An older buffered store holds the store slot ahead of a newly arriving store. While the buffer is not empty, a new store is queued even if its bank is free.
- R7: The buffer holds 4 stores. With 4 held, `st_ready` is 0 and a presented store is not accepted. It is accepted once `st_ready` returns to 1.
- R8: The oldest buffered store is retried every cycle. It is written in the first cycle in which no load targets its bank.
- R9: After reset the buffer is empty, `st_ready` is 1, and no write or bank enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | ADDR_W | Load address |
| ld_grant | output | 1 | Load proceeds to the array this cycle |
| ld_bank_en | output | NUM_BANKS | One-hot bank enable for the load |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| wr_valid | output | 1 | A store is written to the array this cycle |
| wr_addr | output | ADDR_W | Address of the store being written |
| wr_data | output | DATA_W | Data of the store being written |
| st_bank_en | output | NUM_BANKS | One-hot bank enable for the store write |

## Verification
The bound assertions check, on every cycle:
- the load and store enables never share a bank;
- a load is granted whenever it is presented;
- a full buffer lowers ready;
- a same-bank collision blocks the store;
- a free bank lets the oldest candidate through;
- a waiting buffer keeps new stores out of the write slot;
- the buffer fill level moves by exactly one when only one side changes it.

Only the bench scenarios can show that the written addresses and data come out in acceptance order. They also show that a held store enters once space frees up, and that the buffer fully drains after a long run of colliding and free traffic.

// File: rtl/ldst_arb_pkg.sv
package ldst_arb_pkg;

  localparam int unsigned WIDE_AW = 64;
  typedef logic [WIDE_AW-1:0] wide_addr_t;

  // Bank number taken from the address; nbanks must be a power of two.
  function automatic int unsigned bank_of(input wide_addr_t addr,
                                          input int unsigned lsb,
                                          input int unsigned nbanks);
    wide_addr_t shifted;
    shifted = addr >> lsb;
    return shifted[31:0] & (nbanks - 1);
  endfunction

  // Two one-hot bank vectors collide when they share any bit.
  function automatic logic banks_collide(input logic [63:0] a,
                                         input logic [63:0] b);
    return |(a & b);
  endfunction

endpackage

// File: rtl/ldst_bank_dec.sv
module ldst_bank_dec
  import ldst_arb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int BANK_LSB  = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 valid,
  input  logic [ADDR_W-1:0]    addr,
  output logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] bank_en
);

  always_comb begin
    bank    = BANK_W'(bank_of(WIDE_AW'(addr), BANK_LSB, NUM_BANKS));
    bank_en = '0;
    if (valid) bank_en[bank] = 1'b1;
  end

endmodule

// File: rtl/ldst_store_fifo.sv
module ldst_store_fifo #(
  parameter int WIDTH   = 96,
  parameter int DEPTH   = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/ldst_slot_pick.sv
module ldst_slot_pick
  import ldst_arb_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 buf_valid,
  input  logic                 new_valid,
  input  logic [NUM_BANKS-1:0] ld_bank_en,
  input  logic [NUM_BANKS-1:0] cand_bank_en,
  output logic                 sel_buf,
  output logic                 cand_valid,
  output logic                 issue,
  output logic                 pop,
  output logic                 push
);

  logic clash;

  always_comb begin
    // The oldest store always owns the slot: buffer first, then the new one.
    sel_buf    = buf_valid;
    cand_valid = buf_valid | new_valid;
    clash      = banks_collide(64'(ld_bank_en), 64'(cand_bank_en));
    issue      = cand_valid & ~clash;
    pop        = issue & buf_valid;
    push       = new_valid & ~(issue & ~buf_valid);
  end

endmodule

// File: rtl/ldst_bank_arb.sv
module ldst_bank_arb #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 8,
  parameter int BANK_LSB  = 3,
  parameter int SB_DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic [ADDR_W-1:0]    ld_addr,
  output logic                 ld_grant,
  output logic [NUM_BANKS-1:0] ld_bank_en,
  input  logic                 st_valid,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [DATA_W-1:0]    st_data,
  output logic                 st_ready,
  output logic                 wr_valid,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [NUM_BANKS-1:0] st_bank_en
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ENT_W  = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(SB_DEPTH + 1);

  // Named internal events, also observed by the bound checker.
  logic                 st_accept;
  logic                 sb_full, sb_empty;
  logic [CNT_W-1:0]     sb_count;
  logic [ENT_W-1:0]     sb_head;
  logic                 sb_push, sb_pop;
  logic                 cand_valid, wr_from_buf, issue;
  logic [ADDR_W-1:0]    cand_addr;
  logic [DATA_W-1:0]    cand_data;
  logic [BANK_W-1:0]    cand_bank, ld_bank;
  logic [NUM_BANKS-1:0] cand_bank_en;

  assign st_ready  = ~sb_full;
  assign st_accept = st_valid & st_ready;
  assign ld_grant  = ld_valid;   // R2: loads are never refused

  ldst_bank_dec #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_LSB(BANK_LSB)
  ) u_ld_dec (
    .valid(ld_valid), .addr(ld_addr), .bank(ld_bank), .bank_en(ld_bank_en)
  );

  ldst_store_fifo #(.WIDTH(ENT_W), .DEPTH(SB_DEPTH)) u_sbuf (
    .clk(clk), .rst_n(rst_n),
    .push(sb_push), .push_data({st_addr, st_data}),
    .pop(sb_pop), .head(sb_head),
    .count(sb_count), .full(sb_full), .empty(sb_empty)
  );

  always_comb begin
    if (wr_from_buf) begin
      cand_addr = sb_head[ENT_W-1 -: ADDR_W];
      cand_data = sb_head[DATA_W-1:0];
    end else begin
      cand_addr = st_addr;
      cand_data = st_data;
    end
  end

  ldst_bank_dec #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_LSB(BANK_LSB)
  ) u_st_dec (
    .valid(cand_valid), .addr(cand_addr), .bank(cand_bank), .bank_en(cand_bank_en)
  );

  ldst_slot_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
    .buf_valid(~sb_empty), .new_valid(st_accept),
    .ld_bank_en(ld_bank_en), .cand_bank_en(cand_bank_en),
    .sel_buf(wr_from_buf), .cand_valid(cand_valid),
    .issue(issue), .pop(sb_pop), .push(sb_push)
  );

  assign wr_valid   = issue;
  assign wr_addr    = cand_addr;
  assign wr_data    = cand_data;
  assign st_bank_en = issue ? cand_bank_en : '0;

endmodule

// File: rtl/ldst_bank_arb_chk.sv
module ldst_bank_arb_chk #(
  parameter int NUM_BANKS = 8,
  parameter int SB_DEPTH  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(SB_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ld_valid,
  input logic                 ld_grant,
  input logic [NUM_BANKS-1:0] ld_bank_en,
  input logic [NUM_BANKS-1:0] st_bank_en,
  input logic                 st_valid,
  input logic                 st_ready,
  input logic                 wr_valid,
  input logic                 wr_from_buf,
  input logic                 cand_valid,
  input logic [BANK_W-1:0]    cand_bank,
  input logic [BANK_W-1:0]    ld_bank,
  input logic [CNT_W-1:0]     sb_count
);

  p_ld_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $onehot(ld_bank_en));

  p_ld_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> ld_bank_en == '0);

  p_load_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant == ld_valid);

  p_bank_clash_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_bank_en & st_bank_en) == '0);

  p_wr_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $onehot(st_bank_en));

  p_wr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> st_bank_en == '0);

  p_stall_on_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && ld_valid && cand_bank == ld_bank) |-> !wr_valid);

  p_buffer_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_count != '0 && wr_valid) |-> wr_from_buf);

  p_fill_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && st_valid && st_ready) |=> sb_count == CNT_W'($past(sb_count) + 1'b1));

  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_count == CNT_W'(SB_DEPTH)) |-> !st_ready);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sb_count <= CNT_W'(SB_DEPTH));

  p_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !(ld_valid && cand_bank == ld_bank)) |-> wr_valid);

endmodule

bind ldst_bank_arb ldst_bank_arb_chk #(
  .NUM_BANKS(NUM_BANKS), .SB_DEPTH(SB_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ld_valid(ld_valid), .ld_grant(ld_grant),
  .ld_bank_en(ld_bank_en), .st_bank_en(st_bank_en),
  .st_valid(st_valid), .st_ready(st_ready),
  .wr_valid(wr_valid), .wr_from_buf(wr_from_buf),
  .cand_valid(cand_valid), .cand_bank(cand_bank),
  .ld_bank(ld_bank), .sb_count(sb_count)
);

// File: tb/ldst_bank_arb_tb.sv
`timescale 1ns/1ps
module ldst_bank_arb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic        ld_grant;
  logic [7:0]  ld_bank_en;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic        st_ready;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  st_bank_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [95:0] exp_q[$];

  always #2 clk = ~clk;   // 250 MHz

  ldst_bank_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_grant(ld_grant), .ld_bank_en(ld_bank_en),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .st_bank_en(st_bank_en)
  );

  // Bank mask restated from R1: bits [5:3] pick one of 8 banks.
  function automatic logic [7:0] mask_of(input logic [31:0] a);
    logic [7:0] m;
    m = 8'h01 << a[5:3];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus; pushes accepted stores to the scoreboard.
  task automatic drive(input bit lv, input logic [31:0] la, input bit sv,
                       input logic [31:0] sa, input logic [63:0] sd, output bit acc);
    @(negedge clk);
    ld_valid = lv; ld_addr = la;
    st_valid = sv; st_addr = sa; st_data = sd;
    #0.5;
    acc = sv && st_ready;
    if (acc) exp_q.push_back({sa, sd});
  endtask

  // Monitor: compares each write against the scoreboard head.
  initial begin
    logic [95:0] e;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        chk(ld_grant == ld_valid, "R2", "load grant", 64'(ld_grant), 64'(ld_valid));
        chk((ld_bank_en & st_bank_en) == 8'h00, "R3", "bank overlap",
            64'(ld_bank_en & st_bank_en), 64'h0);
        if (wr_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "write with nothing pending", 64'(wr_addr), 64'h0);
          end else begin
            e = exp_q.pop_front();
            chk(wr_addr == e[95:64], "R6", "write order addr", 64'(wr_addr), 64'(e[95:64]));
            chk(wr_data == e[63:0], "R6", "write order data", wr_data, e[63:0]);
            chk(st_bank_en == mask_of(wr_addr), "R4", "store bank enable",
                64'(st_bank_en), 64'(mask_of(wr_addr)));
          end
        end else begin
          chk(st_bank_en == 8'h00, "R4", "idle store enable", 64'(st_bank_en), 64'h0);
        end
      end
    end
  end

  initial begin
    bit acc;
    bit lv, pend;
    logic [31:0] la, pa;
    logic [63:0] pd;
    int guard;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(st_ready == 1'b1, "R9", "ready after reset", 64'(st_ready), 64'h1);
    chk(wr_valid == 1'b0, "R9", "no write after reset", 64'(wr_valid), 64'h0);
    chk(ld_bank_en == 8'h00, "R9", "no load enable after reset", 64'(ld_bank_en), 64'h0);

    // R1/R2: load bank decode
    drive(1, 32'h28, 0, '0, '0, acc);
    chk(ld_bank_en == 8'h20, "R1", "bank 5 decode", 64'(ld_bank_en), 64'h20);
    chk(ld_grant == 1'b1, "R2", "load granted", 64'(ld_grant), 64'h1);
    drive(1, 32'h1F8, 0, '0, '0, acc);
    chk(ld_bank_en == 8'h80, "R1", "bank 7 decode", 64'(ld_bank_en), 64'h80);

    // R4: direct write, alone and alongside a load to another bank
    drive(0, '0, 1, 32'h10, 64'hA1, acc);
    chk(wr_valid && wr_addr == 32'h10, "R4", "direct write", 64'(wr_addr), 64'h10);
    chk(st_bank_en == 8'h04, "R4", "bank 2 enable", 64'(st_bank_en), 64'h04);
    drive(1, 32'h08, 1, 32'h30, 64'hB2, acc);
    chk(wr_valid == 1'b1, "R4", "dual access", 64'(wr_valid), 64'h1);
    chk(ld_bank_en == 8'h02 && st_bank_en == 8'h40, "R4", "both enables",
        64'({ld_bank_en, st_bank_en}), 64'h0240);

    // R5/R8: same-bank collision, then retry
    drive(1, 32'h18, 1, 32'h58, 64'hC3, acc);
    chk(wr_valid == 1'b0, "R5", "store held on clash", 64'(wr_valid), 64'h0);
    chk(ld_grant == 1'b1 && acc, "R5", "load wins, store accepted", 64'({ld_grant, acc}), 64'h3);
    drive(0, '0, 0, '0, '0, acc);
    chk(wr_valid && wr_addr == 32'h58, "R8", "retry when bank free", 64'(wr_addr), 64'h58);

    // R6: a queued store keeps a newer one out of the slot
    drive(1, 32'h20, 1, 32'h60, 64'hD4, acc);
    chk(wr_valid == 1'b0, "R5", "clash on bank 4", 64'(wr_valid), 64'h0);
    drive(1, 32'h20, 1, 32'h08, 64'hE5, acc);
    chk(wr_valid == 1'b0, "R6", "new store queued behind older", 64'(wr_valid), 64'h0);
    drive(0, '0, 0, '0, '0, acc);
    chk(wr_addr == 32'h60, "R6", "older store first", 64'(wr_addr), 64'h60);
    drive(0, '0, 0, '0, '0, acc);
    chk(wr_addr == 32'h08, "R6", "newer store second", 64'(wr_addr), 64'h08);

    // R7: fill the buffer behind a steady bank-5 load
    drive(1, 32'h28, 1, 32'h68, 64'h11, acc);
    drive(1, 32'h28, 1, 32'hA8, 64'h22, acc);
    drive(1, 32'h28, 1, 32'hE8, 64'h33, acc);
    drive(1, 32'h28, 1, 32'h128, 64'h44, acc);
    drive(1, 32'h28, 1, 32'h168, 64'h55, acc);
    chk(st_ready == 1'b0 && !acc, "R7", "full buffer refuses store", 64'({st_ready, acc}), 64'h0);
    drive(1, 32'h28, 1, 32'h168, 64'h55, acc);
    chk(wr_valid == 1'b0, "R5", "held while load keeps bank", 64'(wr_valid), 64'h0);
    guard = 0;
    do begin
      drive(0, '0, 1, 32'h168, 64'h55, acc);
      guard++;
    end while (!acc && guard < 10);
    chk(acc, "R7", "held store accepted after drain", 64'(guard), 64'h2);
    repeat (6) drive(0, '0, 0, '0, '0, acc);
    chk(exp_q.size() == 0, "R8", "buffer drained", 64'(exp_q.size()), 64'h0);

    // Mixed traffic with frequent collisions on banks 0..3
    pend = 0; pa = '0; pd = '0;
    for (int i = 0; i < 3000; i++) begin
      lv = ($urandom % 3) != 0;
      la = ($urandom & 32'h0000_0FC0) | ((32'($urandom % 4)) << 3);
      if (!pend && ($urandom % 2) == 1) begin
        pend = 1;
        pa = ($urandom & 32'h0000_0FC0) | ((32'($urandom % 4)) << 3);
        pd = {$urandom, $urandom};
      end
      drive(lv, la, pend, pa, pd, acc);
      if (acc) pend = 0;
    end
    repeat (8) drive(0, '0, 0, '0, '0, acc);
    chk(exp_q.size() == 0, "R6", "all stores written in order", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule